// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits in a program sequencer and owns the fetch address. In normal flow the fetch address moves up by one each time the pipeline takes a step. A loop-setup command gives a first body address, a last body address and a pass count. From then on the controller compares the fetch address with the stored last address. While passes remain, it sends the fetch back to the first body address. Neither the counting nor the jump back costs an instruction, so the core sees a straight stream with no test-and-branch.

The pass count is fixed when the loop is set up, and the loop always runs to completion. Two special cases follow from that. A body of one instruction is set up with equal first and last addresses and is repeated in place. A count of zero skips the body. Both outputs are registered. Nesting, interrupts and instruction decode are outside this block.

Top module: `zero_overhead_loop`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `fetch_addr` equals the parameter `RESET_ADDR` and `loop_active` is 0.
- R2: With no loop active and no setup accepted, a cycle with `step`=1 makes `fetch_addr` one higher at the next edge, modulo 2^ADDR_W. A cycle with `step`=0 leaves it unchanged.
- R3: A setup (`setup_valid`=1) accepted while no loop is active and with a non-zero `setup_count` sets `fetch_addr` to `setup_start` and `loop_active` to 1 at the next edge.
- R4: When `step`=1 and `fetch_addr` equals the stored last address on a pass that is not the final one, the next `fetch_addr` is the stored first address.
- R5: A loop set up with count N fetches its body exactly N times. After the final pass, `fetch_addr` becomes the last address plus one, modulo 2^ADDR_W.
- R6: `loop_active` falls at the same edge at which the final pass leaves the last address, and not earlier.
- R7: An accepted setup with `setup_count`=0 sets `fetch_addr` to `setup_end`+1, modulo 2^ADDR_W, and leaves `loop_active` at 0.
- R8: With `setup_start`=`setup_end`, the single instruction at that address is fetched N consecutive times, one for each step.
- R9: A setup presented while `loop_active`=1 is ignored. The loop goes on with its original addresses and count.
- R10: While no loop is active, a setup has priority over `step` in the same cycle.
- R11: While a loop is active, a cycle with `step`=0 and no accepted setup changes neither `fetch_addr` nor `loop_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Pipeline takes the current fetch address this cycle |
| setup_valid | input | 1 | Loop-setup command present |
| setup_start | input | ADDR_W | First address of the loop body |
| setup_end | input | ADDR_W | Last address of the loop body |
| setup_count | input | CNT_W | Number of passes, 0 skips the body |
| fetch_addr | output | ADDR_W | Registered fetch address |
| loop_active | output | 1 | A loop is in progress |

## Verification
The properties assume that `step`, `setup_valid` and the setup fields have known values at every rising edge. They also assume that addresses wrap modulo 2^ADDR_W. No legality is required of the first and last addresses. The bench changes inputs only one time unit after a rising edge. It uses only bodies whose first address is not above the last, so the reference model's count of passes stays meaningful. It sends setups in both the idle and the active state, with counts of 0, 1 and the maximum, and with stall cycles inside a loop.

// File: rtl/zol_pkg.sv
package zol_pkg;
  // Source of the next fetch address
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_SEQ   = 2'd1,
    NXT_START = 2'd2,
    NXT_EXIT  = 2'd3
  } nxt_sel_e;
endpackage

// File: rtl/zol_bounds.sv
module zol_bounds #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      first_q <= first_in;
      last_q  <= last_in;
    end
  end
endmodule

// File: rtl/zol_iter.sv
module zol_iter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] left_q,
  output logic             final_pass
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - ONE;
  end

  assign final_pass = (left_q == ONE);
endmodule

// File: rtl/zol_next.sv
module zol_next
  import zol_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  nxt_sel_e          sel,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] first_src,
  input  logic [ADDR_W-1:0] last_src,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (sel)
      NXT_SEQ:   nxt = cur + ONE;
      NXT_START: nxt = first_src;
      NXT_EXIT:  nxt = last_src + ONE;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/zero_overhead_loop.sv
module zero_overhead_loop
  import zol_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          CNT_W      = 8,
  parameter int unsigned RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              setup_valid,
  input  logic [ADDR_W-1:0] setup_start,
  input  logic [ADDR_W-1:0] setup_end,
  input  logic [CNT_W-1:0]  setup_count,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              loop_active
);
  localparam logic [ADDR_W-1:0] RST_PC = ADDR_W'(RESET_ADDR);

  logic [ADDR_W-1:0] fetch_q, start_q, end_q, nxt_addr;
  logic [ADDR_W-1:0] first_src, last_src;
  logic [CNT_W-1:0]  left_q;
  logic              active_q, final_pass;
  logic              accept, at_end, pass_done;
  nxt_sel_e          sel;

  // A setup is taken only when no loop runs
  assign accept    = setup_valid && !active_q;
  assign at_end    = active_q && (fetch_q == end_q);
  assign pass_done = at_end && step && !accept;

  assign first_src = accept ? setup_start : start_q;
  assign last_src  = accept ? setup_end   : end_q;

  always_comb begin
    if (accept)
      sel = (setup_count == '0) ? NXT_EXIT : NXT_START;
    else if (!step)
      sel = NXT_HOLD;
    else if (at_end)
      sel = final_pass ? NXT_EXIT : NXT_START;
    else
      sel = NXT_SEQ;
  end

  zol_bounds #(.ADDR_W(ADDR_W)) u_bounds (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .first_in (setup_start),
    .last_in  (setup_end),
    .first_q  (start_q),
    .last_q   (end_q)
  );

  zol_iter #(.CNT_W(CNT_W)) u_iter (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_val   (setup_count),
    .dec        (pass_done),
    .left_q     (left_q),
    .final_pass (final_pass)
  );

  zol_next #(.ADDR_W(ADDR_W)) u_next (
    .sel       (sel),
    .cur       (fetch_q),
    .first_src (first_src),
    .last_src  (last_src),
    .nxt       (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q  <= RST_PC;
      active_q <= 1'b0;
    end else begin
      fetch_q <= nxt_addr;
      if (accept)
        active_q <= (setup_count != '0);
      else if (pass_done && final_pass)
        active_q <= 1'b0;
    end
  end

  assign fetch_addr  = fetch_q;
  assign loop_active = active_q;
endmodule

// File: rtl/zol_checker.sv
module zol_checker #(
  parameter int          ADDR_W     = 16,
  parameter int          CNT_W      = 8,
  parameter int unsigned RESET_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              setup_valid,
  input logic [ADDR_W-1:0] setup_start,
  input logic [ADDR_W-1:0] setup_end,
  input logic [CNT_W-1:0]  setup_count,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              loop_active,
  input logic [ADDR_W-1:0] start_q,
  input logic [ADDR_W-1:0] end_q,
  input logic [CNT_W-1:0]  left_q
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_ADDR);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fetch_addr == RST_A) && !loop_active);

  p_idle_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!loop_active && !setup_valid && step) |=> fetch_addr == $past(fetch_addr) + ONE_A);

  p_setup_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (!loop_active && setup_valid && setup_count != '0) |=>
      (fetch_addr == $past(setup_start)) && loop_active);

  p_wrap_back_r4: assert property (@(posedge clk) disable iff (rst)
    (loop_active && step && fetch_addr == end_q && left_q > CNT_W'(1)) |=>
      (fetch_addr == $past(start_q)) && loop_active);

  p_final_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (loop_active && step && fetch_addr == end_q && left_q == CNT_W'(1)) |=>
      (fetch_addr == $past(end_q) + ONE_A) && !loop_active);

  p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
    (!loop_active && setup_valid && setup_count == '0) |=>
      (fetch_addr == $past(setup_end) + ONE_A) && !loop_active);

  p_setup_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (loop_active && setup_valid) |=> $stable(start_q) && $stable(end_q));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (loop_active && !step) |=> $stable(fetch_addr) && $stable(loop_active));

  p_count_live_r5: assert property (@(posedge clk) disable iff (rst)
    loop_active |-> left_q != '0);
endmodule

bind zero_overhead_loop zol_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .step(step), .setup_valid(setup_valid),
  .setup_start(setup_start), .setup_end(setup_end), .setup_count(setup_count),
  .fetch_addr(fetch_addr), .loop_active(loop_active),
  .start_q(start_q), .end_q(end_q), .left_q(left_q)
);

// File: tb/zero_overhead_loop_test.sv
`timescale 1ns/1ps
module zero_overhead_loop_test;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int RST_PC = 32'h0100;
  localparam int MASK   = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic setup_valid = 1'b0;
  logic [ADDR_W-1:0] setup_start = '0;
  logic [ADDR_W-1:0] setup_end = '0;
  logic [CNT_W-1:0]  setup_count = '0;
  logic [ADDR_W-1:0] fetch_addr;
  logic loop_active;

  int tests = 0;
  int fails = 0;

  // reference model state
  int  m_pc = RST_PC;
  bit  m_act = 1'b0;
  int  m_start = 0, m_end = 0, m_left = 0;

  always #5 clk = ~clk;

  zero_overhead_loop #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_ADDR(RST_PC)) uut (
    .clk(clk), .rst(rst), .step(step), .setup_valid(setup_valid),
    .setup_start(setup_start), .setup_end(setup_end), .setup_count(setup_count),
    .fetch_addr(fetch_addr), .loop_active(loop_active)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, int'(fetch_addr), m_pc, "fetch_addr");
    check(tag, int'(loop_active), int'(m_act), "loop_active");
  endtask

  // one clock: drive, advance model, compare one time unit after the edge
  task automatic cyc(input bit s, input bit sv, input int st, input int en,
                     input int cnt, input string tag);
    step = s; setup_valid = sv;
    setup_start = ADDR_W'(st); setup_end = ADDR_W'(en); setup_count = CNT_W'(cnt);
    @(posedge clk);
    if (sv && !m_act) begin
      if (cnt == 0) m_pc = (en + 1) & MASK;
      else begin
        m_pc = st; m_act = 1'b1; m_start = st; m_end = en; m_left = cnt;
      end
    end else if (s) begin
      if (m_act && m_pc == m_end) begin
        if (m_left > 1) begin m_pc = m_start; m_left--; end
        else begin m_pc = (m_end + 1) & MASK; m_act = 1'b0; m_left = 0; end
      end else m_pc = (m_pc + 1) & MASK;
    end
    #1;
    compare(tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int visits;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", int'(fetch_addr), RST_PC, "fetch_addr in reset");
    check("R1", int'(loop_active), 0, "loop_active in reset");
    rst = 1'b0;
    cyc(1'b0, 1'b0, 0, 0, 0, "R1");

    // R2: sequential and held
    steps(3, "R2");
    cyc(1'b0, 1'b0, 0, 0, 0, "R2");
    cyc(1'b0, 1'b0, 0, 0, 0, "R2");

    // R3/R4/R5/R6: four-word body, three passes, with stalls and an ignored setup
    cyc(1'b0, 1'b1, 16'h0200, 16'h0203, 3, "R3");
    check("R3", int'(fetch_addr), 16'h0200, "loop entry");
    steps(4, "R4");
    check("R4", int'(fetch_addr), 16'h0200, "back to start");
    cyc(1'b0, 1'b0, 0, 0, 0, "R11");
    cyc(1'b0, 1'b0, 0, 0, 0, "R11");
    cyc(1'b0, 1'b1, 16'h0900, 16'h0901, 7, "R9");
    cyc(1'b1, 1'b1, 16'h0900, 16'h0901, 7, "R9");
    steps(6, "R5");
    check("R6", int'(loop_active), 1, "still active on last word");
    check("R6", int'(fetch_addr), 16'h0203, "at last word");
    cyc(1'b1, 1'b0, 0, 0, 0, "R6");
    check("R5", int'(fetch_addr), 16'h0204, "exit address");
    check("R6", int'(loop_active), 0, "drop on exit");
    steps(2, "R2");

    // R8: single-instruction repeat, count 4
    cyc(1'b0, 1'b1, 16'h0400, 16'h0400, 4, "R8");
    visits = 0;
    for (int i = 0; i < 4; i++) begin
      if (fetch_addr == 16'h0400) visits++;
      cyc(1'b1, 1'b0, 0, 0, 0, "R8");
    end
    check("R8", visits, 4, "repeat visits");
    check("R8", int'(fetch_addr), 16'h0401, "after repeat");

    // R7: zero count skips, including address wrap
    cyc(1'b0, 1'b1, 16'h0500, 16'h7FFF, 0, "R7");
    check("R7", int'(fetch_addr), 16'h8000, "skip target");
    cyc(1'b1, 1'b1, 16'h0600, 16'hFFFF, 0, "R7");
    check("R7", int'(fetch_addr), 0, "skip wrap");
    steps(1, "R2");

    // R10: setup beats step when idle; count 1 single pass
    cyc(1'b1, 1'b1, 16'h0700, 16'h0702, 1, "R10");
    check("R10", int'(fetch_addr), 16'h0700, "setup wins");
    steps(3, "R5");
    check("R5", int'(fetch_addr), 16'h0703, "single pass exit");
    check("R6", int'(loop_active), 0, "single pass drop");

    // R5: maximum count, two-word body
    cyc(1'b0, 1'b1, 16'h0800, 16'h0801, 255, "R5");
    steps(510, "R5");
    check("R5", int'(fetch_addr), 16'h0802, "max count exit");
    check("R6", int'(loop_active), 0, "max count drop");

    // R2: wrap of plain sequential flow
    cyc(1'b0, 1'b1, 16'hFFFE, 16'hFFFE, 0, "R7");
    steps(2, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule